// File: doc/BRIEF.md
# Cascaded Configurable Interrupt Controller

This block gathers up to 96 interrupt sources into one request line for the processor. It is built from three identical 32-source controller units. The first unit is the main controller and feeds the processor. The other two are sub-controllers. Each sub-controller's summary request drives a dedicated input of the main unit. Source numbers 0 to 31 belong to the main unit, 32 to 63 to the first sub-controller and 64 to 95 to the second.

Each source is configured on its own. One bit chooses level or edge sensitivity. A second bit chooses the active sense: high or rising, or low or falling. A per-source enable gates the latched status into a masked status word. Each unit raises its request while any masked bit is set. Software reaches every unit through one 32-bit register bus: a unit select, a register address, a write strobe and a combinational read port. Raw source pins pass through a two-stage synchronizer before any detection.

The cascade lines are active low, like a wired request. The main unit's reset configuration treats them as low-level sources, so its latched bit is set while the sub-controller requests.

Top module: `intc_cascade`

## Requirements
- R1: After reset every enable word is 0 and every request output is 0. The sense word resets to 0x3FF0EFE0 (main), 0xFBD27186 (sub 1) and 0x801810C0 (sub 2). The kind word resets to 0 except 0x00026000 for sub 1.
- R2: For a level source (kind bit 0), the raw status bit is 1 exactly when the pin equals its sense bit (sense 1 = active high, 0 = active low). It updates on the third clock edge after the pin changes.
- R3: For an edge source (kind bit 1), the raw bit latches on a transition of the synchronized pin: rising if the sense bit is 1, falling if it is 0. It sets on the third edge after the pin change and holds until cleared. A transition the other way does not set it.
- R4: Writing the raw-status register clears every edge-source bit written as 1. Bits written as 0 are unchanged. Level-source bits ignore the write.
- R5: If an edge arrives on the same clock edge as a clear of that bit, the bit stays set.
- R6: The masked-status register reads raw status AND enable. An enable bit of 1 passes the source.
- R7: Each unit's request output is the OR of its masked-status bits and changes on the same edge as the enable or raw status.
- R8: The main unit's inputs 0 and 1 carry the inverted requests of sub 1 and sub 2, and the pins src_main[0] and src_main[1] are ignored. A sub request reaches irq_cpu one clock edge after it appears at irq_sub1 or irq_sub2.
- R9: Register map. bus_sel selects the unit: 0 main, 1 sub 1, 2 sub 2; a select of 3 reads 0. bus_addr selects the register: 0 enable, 1 raw status (write-1-to-clear), 2 masked status (read-only; writes are ignored), 3 sense, 4 kind.
- R10: Changing the sense bit of an edge source while its pin is steady latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, sampled on the clock edge |
| bus_sel | input | 2 | Unit select |
| bus_addr | input | 3 | Register select within the unit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| src_main | input | 32 | Raw pins of the main unit |
| src_sub1 | input | 32 | Raw pins of sub-controller 1 |
| src_sub2 | input | 32 | Raw pins of sub-controller 2 |
| irq_cpu | output | 1 | Main unit request to the processor |
| irq_sub1 | output | 1 | Sub-controller 1 summary request |
| irq_sub2 | output | 1 | Sub-controller 2 summary request |

## Verification
Latency from a pin change to the raw status is three clock edges: two synchronizer stages, then the status register. A register write takes effect on the edge that samples it. A request from a sub-controller reaches irq_cpu one edge after it reaches irq_sub1 or irq_sub2.

The bench drives pins and bus signals on falling edges. A behavioural model steps on each rising edge, and the bench compares all outputs and the selected read word 3 ns after that edge.

The directed checks read the raw status once on the second edge, where the bit must still be clear, and once on the third edge, where it must be set. The same-edge clear case is timed so that the write strobe is sampled on the very edge that detects the transition.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned NSRC   = 32;
    localparam int unsigned NSUB   = 2;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned ADDR_W = 3;

    typedef logic [NSRC-1:0] vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 3'd0,
        REG_RAW    = 3'd1,
        REG_PEND   = 3'd2,
        REG_SENSE  = 3'd3,
        REG_KIND   = 3'd4
    } reg_addr_e;

    // unit index 0 is the main controller, 1..NSUB the sub-controllers
    function automatic vec_t sense_default(input int unsigned idx);
        case (idx)
            1:       return 32'hFBD2_7186;
            2:       return 32'h8018_10C0;
            default: return 32'h3FF0_EFE0;
        endcase
    endfunction

    function automatic vec_t kind_default(input int unsigned idx);
        case (idx)
            1:       return 32'h0002_6000;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/intc_unit.sv
module intc_unit
    import intc_pkg::*;
#(
    parameter vec_t SENSE_RST = 32'h0,
    parameter vec_t KIND_RST  = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vec_t              src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  vec_t              wr_data,
    output vec_t              rd_data,
    output logic              irq
);
    vec_t en_q, sense_q, kind_q, raw_q, prev_q;
    logic alive_q;

    vec_t act_now, act_prev, edge_hit, clr_vec, raw_nxt, pend;

    // polarity-adjusted view of the current and previous sample
    assign act_now  = ~(src_in ^ sense_q);
    assign act_prev = ~(prev_q ^ sense_q);
    assign edge_hit = kind_q & act_now & ~act_prev;
    assign clr_vec  = (wr_en && reg_addr == REG_RAW) ? wr_data : '0;
    // edge bits: a new edge beats a clear; level bits track the input
    assign raw_nxt  = (kind_q & ((raw_q & ~clr_vec) | edge_hit)) | (~kind_q & act_now);
    assign pend     = raw_q & en_q;
    assign irq      = |pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            sense_q <= SENSE_RST;
            kind_q  <= KIND_RST;
            raw_q   <= '0;
            prev_q  <= '0;
            alive_q <= 1'b0;
        end else begin
            alive_q <= 1'b1;
            prev_q  <= src_in;
            raw_q   <= raw_nxt;
            if (wr_en && reg_addr == REG_ENABLE) en_q    <= wr_data;
            if (wr_en && reg_addr == REG_SENSE)  sense_q <= wr_data;
            if (wr_en && reg_addr == REG_KIND)   kind_q  <= wr_data;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_ENABLE: rd_data = en_q;
            REG_RAW:    rd_data = raw_q;
            REG_PEND:   rd_data = pend;
            REG_SENSE:  rd_data = sense_q;
            REG_KIND:   rd_data = kind_q;
            default:    rd_data = '0;
        endcase
    end

    // R2: level bits hold the previous cycle's activity
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q |-> (((raw_q ^ $past(act_now)) & ~$past(kind_q)) == '0));

    // R3: a latched edge bit that was not cleared stays set
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alive_q |-> (($past(raw_q & kind_q & ~clr_vec) & ~raw_q) == '0));

    // R7: the request can only rise after a write or a status change
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alive_q && irq && !$past(irq)) |-> ($past(wr_en) || raw_q != $past(raw_q)));

    // R9: a write to the masked-status address changes no configuration
    p_pend_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == REG_PEND) |=> ($stable(en_q) && $stable(sense_q) && $stable(kind_q)));

endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
    import intc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CASC_BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_main,
    input  logic [NSRC-1:0]   src_sub1,
    input  logic [NSRC-1:0]   src_sub2,
    output logic              irq_cpu,
    output logic              irq_sub1,
    output logic              irq_sub2
);
    localparam int unsigned NUNIT = NSUB + 1;
    localparam int unsigned ALL_W = NUNIT * NSRC;

    logic [ALL_W-1:0]           sync_all;
    logic [NSUB-1:0]            sub_irq;
    logic [NSUB-1:0][NSRC-1:0]  sub_rd;
    vec_t                       main_src, main_rd;

    intc_sync #(.W(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({src_sub2, src_sub1, src_main}),
        .q     (sync_all)
    );

    for (genvar g = 0; g < int'(NSUB); g++) begin : g_sub
        intc_unit #(
            .SENSE_RST (sense_default(g + 1)),
            .KIND_RST  (kind_default(g + 1))
        ) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_in   (sync_all[(g+1)*NSRC +: NSRC]),
            .wr_en    (bus_we && bus_sel == SEL_W'(g + 1)),
            .reg_addr (bus_addr),
            .wr_data  (bus_wdata),
            .rd_data  (sub_rd[g]),
            .irq      (sub_irq[g])
        );
    end

    // cascade lines are active low and replace the matching main pins
    always_comb begin
        main_src = sync_all[NSRC-1:0];
        for (int g = 0; g < int'(NSUB); g++) begin
            main_src[CASC_BASE + g] = ~sub_irq[g];
        end
    end

    intc_unit #(
        .SENSE_RST (sense_default(0)),
        .KIND_RST  (kind_default(0))
    ) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (main_src),
        .wr_en    (bus_we && bus_sel == '0),
        .reg_addr (bus_addr),
        .wr_data  (bus_wdata),
        .rd_data  (main_rd),
        .irq      (irq_cpu)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel == '0) bus_rdata = main_rd;
        for (int g = 0; g < int'(NSUB); g++) begin
            if (bus_sel == SEL_W'(g + 1)) bus_rdata = sub_rd[g];
        end
    end

    assign irq_sub1 = sub_irq[0];
    assign irq_sub2 = sub_irq[1];

    // R8: the main request cannot rise on the same edge as a sub request
    p_casc_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_sub1) && $past(u_main.en_q[CASC_BASE]) && !$past(irq_cpu)
            && $stable(u_main.en_q) && $past(u_main.raw_q) == '0) |-> !irq_cpu);

endmodule

// File: tb/intc_cascade_bench.sv
module intc_cascade_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_main = '0, src_sub1 = '0, src_sub2 = '0;
    logic        irq_cpu, irq_sub1, irq_sub2;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_cascade u_intc_cascade (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_main(src_main), .src_sub1(src_sub1), .src_sub2(src_sub2),
        .irq_cpu(irq_cpu), .irq_sub1(irq_sub1), .irq_sub2(irq_sub2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_en[3], m_sense[3], m_kind[3], m_raw[3], m_prev[3], m_s1[3], m_s2[3];
    logic [31:0] m_in[3], m_nraw[3];

    function automatic logic m_req(input int c);
        return (m_raw[c] & m_en[c]) != 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] s, input logic [2:0] a);
        if (s == 2'd3) return 32'h0;
        case (a)
            3'd0: return m_en[s];
            3'd1: return m_raw[s];
            3'd2: return m_raw[s] & m_en[s];
            3'd3: return m_sense[s];
            3'd4: return m_kind[s];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_en[c] = 0; m_raw[c] = 0; m_prev[c] = 0; m_s1[c] = 0; m_s2[c] = 0;
                m_kind[c] = 0;
            end
            m_sense[0] = 32'h3FF0EFE0; m_sense[1] = 32'hFBD27186; m_sense[2] = 32'h801810C0;
            m_kind[1] = 32'h00026000;
        end else begin
            for (int c = 0; c < 3; c++) m_in[c] = m_s2[c];
            m_in[0][0] = !m_req(1);
            m_in[0][1] = !m_req(2);
            for (int c = 0; c < 3; c++) begin
                for (int i = 0; i < 32; i++) begin
                    logic on_now, on_before, cleared;
                    on_now    = (m_in[c][i] == m_sense[c][i]);
                    on_before = (m_prev[c][i] == m_sense[c][i]);
                    cleared   = bus_we && bus_sel == c[1:0] && bus_addr == 3'd1 && bus_wdata[i];
                    if (m_kind[c][i]) begin
                        if (on_now && !on_before) m_nraw[c][i] = 1'b1;
                        else if (cleared)         m_nraw[c][i] = 1'b0;
                        else                      m_nraw[c][i] = m_raw[c][i];
                    end else begin
                        m_nraw[c][i] = on_now;
                    end
                end
            end
            for (int c = 0; c < 3; c++) begin
                m_raw[c]  = m_nraw[c];
                m_prev[c] = m_in[c];
                m_s2[c]   = m_s1[c];
                if (bus_we && bus_sel == c[1:0]) begin
                    if (bus_addr == 3'd0) m_en[c]    = bus_wdata;
                    if (bus_addr == 3'd3) m_sense[c] = bus_wdata;
                    if (bus_addr == 3'd4) m_kind[c]  = bus_wdata;
                end
            end
            m_s1[0] = src_main; m_s1[1] = src_sub1; m_s1[2] = src_sub2;
        end
    end

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check("R7 irq_sub1 vs model", {31'b0, irq_sub1}, {31'b0, m_req(1)});
            check("R7 irq_sub2 vs model", {31'b0, irq_sub2}, {31'b0, m_req(2)});
            check("R8 irq_cpu vs model",  {31'b0, irq_cpu},  {31'b0, m_req(0)});
            check("R9 read data vs model", bus_rdata, m_read(bus_sel, bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] s, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [2:0] a, output logic [31:0] v);
        bus_sel = s; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);

        // R1 reset state
        rd(0, 0, v); check("R1 main enable", v, 32'h0);
        rd(0, 3, v); check("R1 main sense", v, 32'h3FF0EFE0);
        rd(1, 3, v); check("R1 sub1 sense", v, 32'hFBD27186);
        rd(1, 4, v); check("R1 sub1 kind", v, 32'h00026000);
        rd(2, 3, v); check("R1 sub2 sense", v, 32'h801810C0);
        rd(2, 4, v); check("R1 sub2 kind", v, 32'h0);
        check("R1 requests low", {29'b0, irq_cpu, irq_sub1, irq_sub2}, 32'h0);

        // R2 level source on sub2 bit 6 (active high)
        wait_neg(4);
        src_sub2[6] = 1'b1;
        wait_neg(2);
        rd(2, 1, v); check("R2 level not yet", {31'b0, v[6]}, 32'h0);
        wait_neg(1);
        rd(2, 1, v); check("R2 level raw word", v, 32'h7FE7EF7F);

        // R3/R4 falling-edge source on sub1 bit 4
        wr(1, 4, 32'h00026010);
        wr(1, 1, 32'h00000010);
        rd(1, 1, v); check("R4 clear edge bit", {31'b0, v[4]}, 32'h0);
        src_sub1[4] = 1'b1;
        wait_neg(4);
        rd(1, 1, v); check("R3 wrong direction ignored", {31'b0, v[4]}, 32'h0);
        src_sub1[4] = 1'b0;
        wait_neg(2);
        rd(1, 1, v); check("R3 edge not yet", {31'b0, v[4]}, 32'h0);
        wait_neg(1);
        rd(1, 1, v); check("R3 falling edge latched", {31'b0, v[4]}, 32'h1);
        src_sub1[4] = 1'b1;
        wait_neg(4);
        rd(1, 1, v); check("R3 latch holds", {31'b0, v[4]}, 32'h1);
        wr(1, 1, 32'hFFFFFFEF);
        rd(1, 1, v); check("R4 zero bit untouched", {31'b0, v[4]}, 32'h1);
        check("R4 level bit ignores clear", {31'b0, v[0]}, 32'h1);
        wr(1, 1, 32'h00000010);
        rd(1, 1, v); check("R4 one bit cleared", {31'b0, v[4]}, 32'h0);

        // R5 edge detected on the same edge as a clear
        src_sub1[4] = 1'b0;
        wait_neg(1);
        wr(1, 1, 32'h00000010);
        rd(1, 1, v); check("R5 set wins over clear", {31'b0, v[4]}, 32'h1);

        // R10 sense change on a steady pin
        wr(1, 1, 32'h00000010);
        wr(1, 3, 32'hFBD27196);
        wait_neg(4);
        rd(1, 1, v); check("R10 no edge from sense change", {31'b0, v[4]}, 32'h0);
        src_sub1[4] = 1'b1;
        wait_neg(4);
        rd(1, 1, v); check("R3 rising edge latched", {31'b0, v[4]}, 32'h1);

        // R8 cascade; main pin 1 is low (would be active) but must be ignored
        wr(0, 0, 32'h00000002);
        wait_neg(4);
        check("R8 main pin ignored", {31'b0, irq_cpu}, 32'h0);
        wr(2, 0, 32'h00000040);
        check("R7 sub2 request", {31'b0, irq_sub2}, 32'h1);
        check("R8 cpu lags one edge", {31'b0, irq_cpu}, 32'h0);
        wait_neg(1);
        check("R8 cpu follows sub2", {31'b0, irq_cpu}, 32'h1);
        rd(2, 2, v); check("R6 masked status", v, 32'h00000040);

        // R9 map: masked status read-only, select 3 reads zero
        wr(2, 2, 32'hFFFFFFFF);
        rd(2, 0, v); check("R9 enable unchanged", v, 32'h00000040);
        rd(2, 2, v); check("R9 masked unchanged", v, 32'h00000040);
        rd(3, 0, v); check("R9 select 3 reads zero", v, 32'h0);

        // R6/R7 masking removes the request
        wr(2, 0, 32'h0);
        check("R7 sub2 drops", {31'b0, irq_sub2}, 32'h0);
        rd(2, 2, v); check("R6 masked empty", v, 32'h0);
        wait_neg(1);
        check("R8 cpu drops", {31'b0, irq_cpu}, 32'h0);

        wait_neg(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule